// File: doc/BRIEF.md
# Flow-Through Prefetch Read Controller

This block supervises a prefetchable read whose data travels from a target-side bus, through a read data buffer, to an initiator that repeats its request. It keeps the occupancy count of the buffer from the push and pop strobes. It also decides, each cycle, whether a buffered word may be handed to the initiator. There are two ways a word can be handed over. In the plain store-and-forward case the target-side read must have finished first. In the streaming case the initiator starts draining while the target-side read is still running and before that read has hit a read boundary. From then on data flows through the buffer and long bursts are kept up.

While streaming, the block asks the target side to stop as soon as any one of these holds: the initiator terminates, the word being pushed is the last DWORD of an aligned 4 KB page, or the buffer is full. Each word taken by the initiator is flagged as a disconnect-with-data when it empties the buffer. This covers both the stalled stream and the final DWORD of a completed read. If the initiator terminates while words are still buffered, a one-cycle flush clears them.

Top module: `ftrd_ctrl`

## Requirements
- R1: After a synchronous active-low reset, occ is 0, ft_mode is 0, and ini_xfer, ini_disc, tgt_stop and buf_flush are all 0 while the inputs are idle.
- R2: A tgt_push raises occ by one when occ is below DEPTH. A push at occ equal to DEPTH is ignored and occ stays at DEPTH. Every ini_xfer lowers occ by one.
- R3: While tgt_busy and tgt_bnd are both 1 and ft_mode is 0, ini_req yields no ini_xfer. With tgt_busy at 0, each ini_req cycle with occ above 0 yields ini_xfer, and ft_mode stays 0.
- R4: An ini_req with tgt_busy 1, tgt_bnd 0 and occ above 0 yields ini_xfer in that cycle. ft_mode is 1 from the next cycle on, unless that word emptied the buffer.
- R5: ini_disc is 1 exactly in the cycles where ini_xfer takes the only buffered word and no push is accepted in that cycle.
- R6: In streaming mode, tgt_stop is 1 whenever occ equals DEPTH.
- R7: In streaming mode, tgt_stop is 1 in a cycle where tgt_push carries a tgt_idx of all ones (the last DWORD of a 4 KB page). It is 0 for any other index when no other stop condition holds.
- R8: In streaming mode, tgt_stop is 1 in any cycle where ini_stop is 1.
- R9: buf_flush is 1 in a cycle where ini_stop is 1 and occ is above 0. There is no ini_xfer in any ini_stop cycle, and occ is 0 in the cycle after a flush.
- R10: ft_mode returns to 0 in the cycle after an ini_disc or an ini_stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_busy | input | 1 | Target-side read still in progress |
| tgt_bnd | input | 1 | Target-side read has reached a read boundary |
| tgt_push | input | 1 | Target side writes one DWORD into the buffer |
| tgt_idx | input | IDXW (10) | DWORD index within the 4 KB page of the pushed word (address bits 11..2) |
| ini_req | input | 1 | Initiator wants a word this cycle |
| ini_stop | input | 1 | Initiator terminates the transfer |
| ini_xfer | output | 1 | A buffered word is handed to the initiator |
| ini_disc | output | 1 | Disconnect with data, qualifies ini_xfer |
| tgt_stop | output | 1 | Stop request to the target-side read |
| ft_mode | output | 1 | Streaming (flow-through) mode active |
| buf_flush | output | 1 | One-cycle discard of buffered words |
| occ | output | CW (4) | Buffer occupancy count |

## Verification
A wrong occupancy count shows at occ in the cycle after the faulty push or pop. It also shows in the same cycle as a misplaced ini_disc, because the disconnect is decided from the count. A mode flag stuck in the wrong state shows at once. Either an ini_xfer appears while the target-side read is still busy past its boundary, or tgt_stop fails to rise at a full buffer or a page end. The bench sweeps every fill level from one to DEPTH in both delivery modes and counts each handed word and the disconnect position.

// File: rtl/ftrd_pkg.sv
// Package: shared constants for the flow-through read controller.
// Assumes DWORD-addressed data and 4 KB pages.
package ftrd_pkg;
    localparam int PAGE_BYTES = 4096;
    localparam int DW_BYTES   = 4;
    // Width of the DWORD index inside one page (address bits 11..2).
    localparam int IDXW = $clog2(PAGE_BYTES / DW_BYTES);
endpackage

// File: rtl/ftrd_occ.sv
// Module: buffer occupancy counter.
// Counts pushed minus popped words and saturates at DEPTH (a push into a full
// buffer is dropped). A clear wins over everything else.
// Assumes pop is only asserted when the count is above zero.
module ftrd_occ #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clr,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty,
    output logic          push_ok
);
    logic [CW-1:0] occ_nxt;

    // Status flags derived from the current count.
    always_comb begin
        full    = (occ == CW'(DEPTH));
        empty   = (occ == '0);
        push_ok = push && !full;
    end

    // Next count from accepted push and pop.
    always_comb begin
        occ_nxt = occ;
        if (push_ok) occ_nxt = occ_nxt + CW'(1);
        if (pop)     occ_nxt = occ_nxt - CW'(1);
    end

    // Count register with clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   occ <= '0;
        else if (clr) occ <= '0;
        else          occ <= occ_nxt;
    end

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));
    // R2
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (occ != '0));
    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (occ == '0));
endmodule

// File: rtl/ftrd_mode.sv
// Module: streaming-mode flag.
// Sets when a word is taken while the target-side read is still busy.
// Clears when the transfer ends by a disconnect or an initiator stop.
// Assumes take is only asserted when delivery is allowed.
module ftrd_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic tgt_busy,
    input  logic disc,
    input  logic stop,
    output logic ft
);
    logic enter, leave;

    // Entry and exit conditions.
    always_comb begin
        enter = take && tgt_busy && !ft;
        leave = stop || disc;
    end

    // Mode register, exit has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     ft <= 1'b0;
        else if (leave) ft <= 1'b0;
        else if (enter) ft <= 1'b1;
    end

    // R4
    ft_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ft) |-> $past(tgt_busy) && $past(take));
    // R10
    ft_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> !ft);
endmodule

// File: rtl/ftrd_term.sv
// Module: streaming termination logic.
// Raises the target stop request in streaming mode on an initiator stop,
// a full buffer, or a push of the last DWORD of a 4 KB page.
// Assumes idx is the in-page DWORD index of the word being pushed.
module ftrd_term
    import ftrd_pkg::*;
(
    input  logic            ft,
    input  logic            full,
    input  logic            ini_stop,
    input  logic            push,
    input  logic [IDXW-1:0] idx,
    output logic            tgt_stop
);
    logic page_end;

    // Page-end detect and first-of-three stop decision.
    always_comb begin
        page_end = push && (&idx);
        tgt_stop = ft && (ini_stop || full || page_end);
    end
endmodule

// File: rtl/ftrd_ctrl.sv
// Module: flow-through prefetch read controller (top).
// Gates delivery of buffered words to the initiator. Delivery happens
// store-and-forward once the target-side read is done, or as a stream
// when draining starts before the target-side read hits a boundary.
// Flags the disconnect-with-data word, asks the target side to stop,
// and flushes leftovers on an early initiator stop.
// Assumes the buffer storage follows ini_xfer, tgt_push and buf_flush.
module ftrd_ctrl
    import ftrd_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tgt_busy,
    input  logic            tgt_bnd,
    input  logic            tgt_push,
    input  logic [IDXW-1:0] tgt_idx,
    input  logic            ini_req,
    input  logic            ini_stop,
    output logic            ini_xfer,
    output logic            ini_disc,
    output logic            tgt_stop,
    output logic            ft_mode,
    output logic            buf_flush,
    output logic [CW-1:0]   occ
);
    logic full, empty, push_ok, can_give;

    ftrd_occ #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .push(tgt_push), .pop(ini_xfer),
        .clr(buf_flush), .occ(occ), .full(full), .empty(empty),
        .push_ok(push_ok)
    );

    ftrd_mode u_mode (
        .clk(clk), .rst_n(rst_n), .take(ini_xfer), .tgt_busy(tgt_busy),
        .disc(ini_disc), .stop(ini_stop), .ft(ft_mode)
    );

    ftrd_term u_term (
        .ft(ft_mode), .full(full), .ini_stop(ini_stop), .push(tgt_push),
        .idx(tgt_idx), .tgt_stop(tgt_stop)
    );

    // Delivery gate, disconnect and flush decisions.
    always_comb begin
        can_give  = !empty && !ini_stop &&
                    (ft_mode || !tgt_busy || !tgt_bnd);
        ini_xfer  = ini_req && can_give;
        ini_disc  = ini_xfer && (occ == CW'(1)) && !push_ok;
        buf_flush = ini_stop && !empty;
    end

    // R5
    disc_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ini_disc |-> ini_xfer);
    // R9
    flush_noxfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ini_stop |-> !ini_xfer);
    // R3
    bnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_busy && tgt_bnd && !ft_mode) |-> !ini_xfer);
    // R5
    disc_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ini_disc |=> (occ == '0) || $past(buf_flush));
endmodule

// File: tb/sim_ftrd_ctrl.sv
module sim_ftrd_ctrl;
    import ftrd_pkg::*;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic tgt_busy = 0, tgt_bnd = 0, tgt_push = 0, ini_req = 0, ini_stop = 0;
    logic [IDXW-1:0] tgt_idx = '0;
    logic ini_xfer, ini_disc, tgt_stop, ft_mode, buf_flush;
    logic [CW-1:0] occ;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ftrd_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .tgt_busy(tgt_busy), .tgt_bnd(tgt_bnd),
        .tgt_push(tgt_push), .tgt_idx(tgt_idx), .ini_req(ini_req),
        .ini_stop(ini_stop), .ini_xfer(ini_xfer), .ini_disc(ini_disc),
        .tgt_stop(tgt_stop), .ft_mode(ft_mode), .buf_flush(buf_flush),
        .occ(occ)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one clock, leave at the next falling edge plus settle time.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        tgt_push = 0; ini_req = 0; ini_stop = 0; tgt_idx = '0;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            tgt_push = 1; tgt_idx = IDXW'(16 + i);
            cyc();
        end
        tgt_push = 0;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); #1;
        cyc(); cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 occ", int'(occ), 0);
        chk("R1 ft_mode", int'(ft_mode), 0);
        chk("R1 outputs", int'({ini_xfer, ini_disc, tgt_stop, buf_flush}), 0);

        // R3 R5 store-and-forward sweep over every fill level
        for (int n = 1; n <= DEPTH; n++) begin
            tgt_busy = 1; tgt_bnd = 0;
            push_n(n);
            chk("R2 occ after push", int'(occ), n);
            tgt_bnd = 1; ini_req = 1; #1;
            chk("R3 held past boundary", int'(ini_xfer), 0);
            cyc();
            ini_req = 0; tgt_busy = 0; tgt_bnd = 0;
            cyc();
            for (int i = 0; i < n; i++) begin
                ini_req = 1; #1;
                chk("R3 sf xfer", int'(ini_xfer), 1);
                chk("R5 sf disc", int'(ini_disc), (i == n - 1) ? 1 : 0);
                cyc();
                chk("R3 sf mode", int'(ft_mode), 0);
                chk("R2 occ after pop", int'(occ), n - 1 - i);
            end
            idle(); cyc();
        end

        // R4 R5 R10 streaming sweep over every fill level
        for (int n = 1; n <= DEPTH; n++) begin
            tgt_busy = 1; tgt_bnd = 0;
            push_n(n);
            ini_req = 1; #1;
            chk("R4 entry xfer", int'(ini_xfer), 1);
            chk("R5 entry disc", int'(ini_disc), (n == 1) ? 1 : 0);
            cyc();
            chk("R4 ft_mode", int'(ft_mode), (n > 1) ? 1 : 0);
            for (int i = 1; i < n; i++) begin
                tgt_bnd = 1; #1;
                chk("R4 stream xfer", int'(ini_xfer), 1);
                chk("R5 stream disc", int'(ini_disc), (i == n - 1) ? 1 : 0);
                cyc();
            end
            chk("R10 ft after disc", int'(ft_mode), 0);
            chk("R2 occ drained", int'(occ), 0);
            idle(); tgt_bnd = 0; cyc();
        end

        // R5 last word taken while a push lands: no disconnect
        tgt_busy = 1; push_n(2);
        ini_req = 1; cyc();
        tgt_push = 1; tgt_idx = IDXW'(40); #1;
        chk("R5 push same cycle", int'(ini_disc), 0);
        cyc(); idle();
        chk("R2 occ push+pop", int'(occ), 1);
        chk("R4 ft kept", int'(ft_mode), 1);

        // R6 full buffer, R2 dropped push, R8 R9 early stop
        push_n(DEPTH - 1);
        chk("R2 occ full", int'(occ), DEPTH);
        #1;
        chk("R6 stop at full", int'(tgt_stop), 1);
        tgt_push = 1; cyc(); tgt_push = 0;
        chk("R2 push at full ignored", int'(occ), DEPTH);
        ini_stop = 1; ini_req = 1; #1;
        chk("R8 stop on ini_stop", int'(tgt_stop), 1);
        chk("R9 flush", int'(buf_flush), 1);
        chk("R9 no xfer", int'(ini_xfer), 0);
        cyc(); idle();
        chk("R9 occ cleared", int'(occ), 0);
        chk("R10 ft after stop", int'(ft_mode), 0);
        chk("R9 no flush when empty", int'(buf_flush), 0);

        // R7 page end
        push_n(2);
        ini_req = 1; cyc(); ini_req = 0;
        tgt_push = 1; tgt_idx = '1; #1;
        chk("R7 page end stop", int'(tgt_stop), 1);
        tgt_idx = IDXW'((1 << IDXW) - 2); #1;
        chk("R7 not page end", int'(tgt_stop), 0);
        tgt_push = 0; tgt_idx = '1; #1;
        chk("R7 index without push", int'(tgt_stop), 0);
        cyc();
        ini_stop = 1; cyc(); idle(); tgt_busy = 0;
        chk("R9 occ after page test", int'(occ), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule